// File: doc/BRIEF.md
# Timer Compare-Output Unit

This block is the output-compare slice of an eight-channel timer. A 16-bit counter steps once on each clock on which the `tick` input is high. Each channel holds a 16-bit compare value. When the counter steps onto that value, the channel raises its compare flag and applies its programmed action to an internal output latch. The action is one of four: leave the latch alone, invert it, clear it or set it. When the counter wraps from all ones to zero, an overflow flag goes high.

Each channel drives one pin. While the channel's action code is nonzero, the compare logic owns the pin and the pin is an output, whatever the direction register holds. While the code is zero, the pin falls back to the general-purpose data and direction registers, and the compare latch keeps its value.

Software clears the flags by writing ones to them. It can instead turn on a fast-clear mode. In that mode, writing a compare register clears that channel's flag, and any access to the counter clears the overflow flag. Programming uses a byte-wide register bus with a combinational read path. A write or read takes effect on the rising clock edge at which its strobe is high.

Top module: `tmr_cmp_unit`

## Requirements
- R1: The counter resets to 0 and advances by one on each clock edge at which `tick` is high. It holds its value otherwise. It reads back as a high byte at address 0x00 and a low byte at 0x01.
- R2: Each channel has a 2-bit action code. Codes for channels 7..4 sit in the register at 0x02 and codes for channels 3..0 in the register at 0x03. Channel n uses bit 2·(n mod 4)+1 as its mode bit and bit 2·(n mod 4) as its level bit. Both registers read back as written.
- R3: The compare value of channel n is at 0x10+2n (high byte) and 0x11+2n (low byte). On the clock edge at which `tick` moves the counter onto that value, bit n of the flag register at 0x04 is set. On the same edge the latch takes the action given by the code: 01 inverts it, 10 clears it, 11 sets it and 00 leaves it unchanged.
- R4: While a channel's code is nonzero, its `pin_oe` bit is 1 and its `pin_out` bit equals the compare latch. While the code is 00, `pin_out` equals bit n of the port data register at 0x07 and `pin_oe` equals bit n of the port direction register at 0x08.
- R5: The compare latch keeps its value while its channel is disconnected. It reappears on the pin when any nonzero code is programmed again.
- R6: Writing 1 to a bit of the flag register at 0x04, or to bit 7 of the overflow register at 0x05, clears that flag. Writing 0 to a bit leaves it as it was.
- R7: The overflow flag, which reads as bit 7 of 0x05, is set on the edge at which `tick` wraps the counter from 0xFFFF to 0x0000.
- R8: Bit 0 of the register at 0x06 enables fast-clear mode. With the mode on, a write to either byte of channel n's compare value clears flag n. With the mode off, such a write does not clear the flag.
- R9: With fast-clear mode on, a read or write of either counter byte clears the overflow flag. With the mode off, such an access leaves the flag set.
- R10: If a flag would be set and cleared on the same edge, it ends up set.
- R11: After reset, every register reads 0 and `pin_out` and `pin_oe` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Counter step enable |
| bus_addr | input | 6 | Register address |
| bus_rd | input | 1 | Read strobe (side effects on the edge) |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational on address |
| pin_out | output | 8 | Pin output values |
| pin_oe | output | 8 | Pin output enables |

## Verification
The bench targets the cases a careless implementation gets wrong:

- **Set-versus-clear priority.** A fast-clearing compare write lands on the same edge as that channel's match. A design that gives the clear priority reads back a zero flag.
- **Latch retention.** A channel is disconnected and then reconnected with no match in between. A design that resets or re-derives the latch shows the wrong pin value.
- **Writing zero to the flag register.** A design that loads the flag register as plain data loses flags when a zero is written.
- **Mode off versus mode on.** Compare writes and counter reads are repeated with fast-clear off and then on. A design that ignores the mode bit clears flags it should keep, or keeps flags it should clear.
- **Counter wrap, twice.** The counter is run through a full wrap two times. This checks that the overflow flag appears, survives a counter read when the mode is off, and clears only on a one-write.

// File: rtl/tmr_cmp_pkg.sv
// Package: shared constants for the timer compare-output unit.
// Assumes a 6-bit register address and byte-wide data; compare registers
// start at CMP_BASE, two bytes per channel.
package tmr_cmp_pkg;

    localparam int DATA_W = 8;
    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] A_CNT_HI  = 6'h00;
    localparam logic [ADDR_W-1:0] A_CNT_LO  = 6'h01;
    localparam logic [ADDR_W-1:0] A_ACT_HI  = 6'h02;
    localparam logic [ADDR_W-1:0] A_ACT_LO  = 6'h03;
    localparam logic [ADDR_W-1:0] A_CHFLG   = 6'h04;
    localparam logic [ADDR_W-1:0] A_OVFLG   = 6'h05;
    localparam logic [ADDR_W-1:0] A_CFG     = 6'h06;
    localparam logic [ADDR_W-1:0] A_PDATA   = 6'h07;
    localparam logic [ADDR_W-1:0] A_PDIR    = 6'h08;
    localparam logic [ADDR_W-1:0] A_CMP_BASE = 6'h10;

    // Bit position of the overflow flag inside its register.
    localparam int OVF_BIT = 7;

    typedef enum logic [1:0] {
        ACT_OFF  = 2'b00,
        ACT_TOG  = 2'b01,
        ACT_LOW  = 2'b10,
        ACT_HIGH = 2'b11
    } oc_act_e;

endpackage

// File: rtl/tmr_free_counter.sv
// Module: free-running up-counter for the compare unit.
// Steps by one on each clock with tick high and wraps silently.
// Provides the next count value so compare logic can detect the value
// the counter is about to take, plus a wrap strobe for the overflow flag.
module tmr_free_counter #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    output logic [CW-1:0] cnt_q,
    output logic [CW-1:0] cnt_nxt,
    output logic          wrap
);

    localparam logic [CW-1:0] CNT_ONE = {{(CW-1){1'b0}}, 1'b1};
    localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};

    // Next value and wrap detection.
    assign cnt_nxt = cnt_q + CNT_ONE;
    assign wrap    = tick && (cnt_q == CNT_MAX);

    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_nxt;
        end
    end

endmodule

// File: rtl/tmr_oc_channel.sv
// Module: one output-compare channel.
// Holds the compare value (written as two bytes), the compare flag and the
// output latch, and muxes the pin between compare logic and the port
// registers. Assumes CW == 2*DW. A match sets the flag even when the
// channel is disconnected; setting wins over a same-cycle clear.
module tmr_oc_channel
    import tmr_cmp_pkg::*;
#(
    parameter int CW = 16,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [CW-1:0] cnt_nxt,
    input  logic          cmp_wr_hi,
    input  logic          cmp_wr_lo,
    input  logic [DW-1:0] wdata,
    input  logic [1:0]    act,
    input  logic          flag_clr,
    input  logic          port_d,
    input  logic          port_dir,
    output logic [CW-1:0] cmp_q,
    output logic          flag_q,
    output logic          latch_q,
    output logic          pin_o,
    output logic          pin_e
);

    logic    hit;
    logic    connected;
    oc_act_e act_e;

    // Match on the edge at which the counter steps onto the compare value.
    assign hit       = tick && (cnt_nxt == cmp_q);
    assign act_e     = oc_act_e'(act);
    assign connected = (act_e != ACT_OFF);

    // Compare value, written a byte at a time.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= '0;
        end else begin
            if (cmp_wr_hi) cmp_q[CW-1:DW] <= wdata;
            if (cmp_wr_lo) cmp_q[DW-1:0]  <= wdata;
        end
    end

    // Compare flag: set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (hit) begin
            flag_q <= 1'b1;
        end else if (flag_clr) begin
            flag_q <= 1'b0;
        end
    end

    // Output latch: apply the programmed action on a match.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= 1'b0;
        end else if (hit) begin
            unique case (act_e)
                ACT_TOG:  latch_q <= ~latch_q;
                ACT_LOW:  latch_q <= 1'b0;
                ACT_HIGH: latch_q <= 1'b1;
                default:  latch_q <= latch_q;
            endcase
        end
    end

    // Pin ownership: compare logic overrides the port registers when active.
    assign pin_o = connected ? latch_q : port_d;
    assign pin_e = connected | port_dir;

endmodule

// File: rtl/tmr_bus_regs.sv
// Module: register bus front end of the compare unit.
// Decodes the byte bus, holds the action codes, port data/direction,
// fast-clear mode bit and overflow flag, builds per-channel strobes
// and flag-clear requests, and drives the combinational read mux.
// Assumes NCH <= 8 so that action codes fit in two byte registers.
module tmr_bus_regs
    import tmr_cmp_pkg::*;
#(
    parameter int NCH = 8,
    parameter int CW  = 16,
    parameter int DW  = 8,
    parameter int AW  = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [AW-1:0]      addr,
    input  logic               rd,
    input  logic               wr,
    input  logic [DW-1:0]      wdata,
    input  logic [CW-1:0]      cnt_q,
    input  logic               wrap,
    input  logic [NCH-1:0]     ch_flag,
    input  logic [NCH*CW-1:0]  cmp_bus,
    output logic [2*NCH-1:0]   act_code,
    output logic [NCH-1:0]     pdata,
    output logic [NCH-1:0]     pdir,
    output logic [NCH-1:0]     cmp_wr_hi,
    output logic [NCH-1:0]     cmp_wr_lo,
    output logic [NCH-1:0]     flag_clr,
    output logic               ovf_flag,
    output logic [DW-1:0]      rdata
);

    localparam int ACT_W = 2 * NCH;

    logic [DW-1:0] act_hi_q;
    logic [DW-1:0] act_lo_q;
    logic          fast_q;
    logic          cnt_access;
    logic          ovf_clr;
    logic [2*DW-1:0] act_all;

    // Access decode for the counter bytes (read or write).
    assign cnt_access = (rd || wr) && ((addr == A_CNT_HI) || (addr == A_CNT_LO));

    // Overflow clear: write-one or fast-clear counter access.
    assign ovf_clr = (wr && (addr == A_OVFLG) && wdata[OVF_BIT])
                   || (fast_q && cnt_access);

    assign act_all  = {act_hi_q, act_lo_q};
    assign act_code = act_all[ACT_W-1:0];

    // Per-channel compare write strobes and flag-clear requests.
    for (genvar n = 0; n < NCH; n++) begin : g_chdec
        localparam logic [AW-1:0] A_HI = A_CMP_BASE + AW'(2 * n);
        localparam logic [AW-1:0] A_LO = A_CMP_BASE + AW'(2 * n + 1);
        assign cmp_wr_hi[n] = wr && (addr == A_HI);
        assign cmp_wr_lo[n] = wr && (addr == A_LO);
        assign flag_clr[n]  = (wr && (addr == A_CHFLG) && wdata[n])
                            || (fast_q && (cmp_wr_hi[n] || cmp_wr_lo[n]));
    end

    // Control and port registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_hi_q <= '0;
            act_lo_q <= '0;
            pdata    <= '0;
            pdir     <= '0;
            fast_q   <= 1'b0;
        end else if (wr) begin
            if (addr == A_ACT_HI) act_hi_q <= wdata;
            if (addr == A_ACT_LO) act_lo_q <= wdata;
            if (addr == A_PDATA)  pdata    <= wdata[NCH-1:0];
            if (addr == A_PDIR)   pdir     <= wdata[NCH-1:0];
            if (addr == A_CFG)    fast_q   <= wdata[0];
        end
    end

    // Overflow flag: wrap has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_flag <= 1'b0;
        end else if (wrap) begin
            ovf_flag <= 1'b1;
        end else if (ovf_clr) begin
            ovf_flag <= 1'b0;
        end
    end

    // Read mux, combinational on the address.
    always_comb begin
        rdata = '0;
        unique case (addr)
            A_CNT_HI: rdata = cnt_q[CW-1:DW];
            A_CNT_LO: rdata = cnt_q[DW-1:0];
            A_ACT_HI: rdata = act_hi_q;
            A_ACT_LO: rdata = act_lo_q;
            A_CHFLG:  rdata = DW'(ch_flag);
            A_OVFLG:  rdata[OVF_BIT] = ovf_flag;
            A_CFG:    rdata[0] = fast_q;
            A_PDATA:  rdata = DW'(pdata);
            A_PDIR:   rdata = DW'(pdir);
            default: begin
                for (int n = 0; n < NCH; n++) begin
                    if (addr == A_CMP_BASE + AW'(2 * n))
                        rdata = cmp_bus[n*CW + DW +: DW];
                    if (addr == A_CMP_BASE + AW'(2 * n + 1))
                        rdata = cmp_bus[n*CW +: DW];
                end
            end
        endcase
    end

endmodule

// File: rtl/tmr_cmp_unit.sv
// Module: top of the timer compare-output unit.
// Ties the counter, the register front end and NCH compare channels
// together. Assumes NCH <= 8 and CW == 2*DW (byte-split counter and
// compare registers).
module tmr_cmp_unit
    import tmr_cmp_pkg::*;
#(
    parameter int NCH = 8,
    parameter int CW  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [NCH-1:0]    pin_out,
    output logic [NCH-1:0]    pin_oe
);

    logic [CW-1:0]      cnt_q;
    logic [CW-1:0]      cnt_nxt;
    logic               wrap;
    logic [2*NCH-1:0]   act_code;
    logic [NCH-1:0]     pdata;
    logic [NCH-1:0]     pdir;
    logic [NCH-1:0]     cmp_wr_hi;
    logic [NCH-1:0]     cmp_wr_lo;
    logic [NCH-1:0]     flag_clr;
    logic [NCH-1:0]     ch_flag;
    logic [NCH-1:0]     oc_latch;
    logic [NCH*CW-1:0]  cmp_bus;
    logic               ovf_flag;

    // Free-running counter.
    tmr_free_counter #(.CW(CW)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .cnt_q   (cnt_q),
        .cnt_nxt (cnt_nxt),
        .wrap    (wrap)
    );

    // Register bus front end.
    tmr_bus_regs #(.NCH(NCH), .CW(CW), .DW(DATA_W), .AW(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (bus_addr),
        .rd        (bus_rd),
        .wr        (bus_wr),
        .wdata     (bus_wdata),
        .cnt_q     (cnt_q),
        .wrap      (wrap),
        .ch_flag   (ch_flag),
        .cmp_bus   (cmp_bus),
        .act_code  (act_code),
        .pdata     (pdata),
        .pdir      (pdir),
        .cmp_wr_hi (cmp_wr_hi),
        .cmp_wr_lo (cmp_wr_lo),
        .flag_clr  (flag_clr),
        .ovf_flag  (ovf_flag),
        .rdata     (bus_rdata)
    );

    // One compare channel per pin.
    for (genvar n = 0; n < NCH; n++) begin : g_ch
        tmr_oc_channel #(.CW(CW), .DW(DATA_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .tick      (tick),
            .cnt_nxt   (cnt_nxt),
            .cmp_wr_hi (cmp_wr_hi[n]),
            .cmp_wr_lo (cmp_wr_lo[n]),
            .wdata     (bus_wdata),
            .act       (act_code[2*n +: 2]),
            .flag_clr  (flag_clr[n]),
            .port_d    (pdata[n]),
            .port_dir  (pdir[n]),
            .cmp_q     (cmp_bus[n*CW +: CW]),
            .flag_q    (ch_flag[n]),
            .latch_q   (oc_latch[n]),
            .pin_o     (pin_out[n]),
            .pin_e     (pin_oe[n])
        );
    end

endmodule

// File: rtl/tmr_cmp_unit_chk.sv
// Module: assertion checker for the compare unit, bound to the top.
// Recomputes match events from the counter and compare values and checks
// counter stepping, flag setting, overflow, pin ownership and latch hold.
module tmr_cmp_unit_chk #(
    parameter int NCH = 8,
    parameter int CW  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic [CW-1:0]     cnt,
    input logic              ovf,
    input logic [NCH-1:0]    flags,
    input logic [NCH-1:0]    latch,
    input logic [2*NCH-1:0]  act,
    input logic [NCH*CW-1:0] cmp_all,
    input logic [NCH-1:0]    pin_oe
);

    logic [NCH-1:0] hit_m;
    logic [NCH-1:0] act_on;

    // Expected match events and active-channel mask.
    always_comb begin
        for (int n = 0; n < NCH; n++) begin
            hit_m[n]  = tick && (cmp_all[n*CW +: CW] == cnt + {{(CW-1){1'b0}}, 1'b1});
            act_on[n] = |act[2*n +: 2];
        end
    end

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (cnt == $past(cnt) + {{(CW-1){1'b0}}, 1'b1})); // R1

    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt)); // R1

    AST_FLAG_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        (|hit_m) |=> ((flags & $past(hit_m)) == $past(hit_m))); // R10

    AST_OVF_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (cnt == {CW{1'b1}})) |=> ovf); // R7

    AST_PIN_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        (|act_on) |-> ((pin_oe & act_on) == act_on)); // R4

    AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (|(~act_on)) |=> (((latch ^ $past(latch)) & ~$past(act_on)) == '0)); // R5

endmodule

bind tmr_cmp_unit tmr_cmp_unit_chk #(.NCH(NCH), .CW(CW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick),
    .cnt     (cnt_q),
    .ovf     (ovf_flag),
    .flags   (ch_flag),
    .latch   (oc_latch),
    .act     (act_code),
    .cmp_all (cmp_bus),
    .pin_oe  (pin_oe)
);

// File: tb/tmr_cmp_unit_test.sv
// Bench: vector table walked by one loop, then directed tests for reset,
// set-over-clear priority, counter wrap and fast-clear of the overflow flag.
module tmr_cmp_unit_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [5:0] bus_addr = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pin_out;
    logic [7:0] pin_oe;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    tmr_cmp_unit uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pin_out   (pin_out),
        .pin_oe    (pin_oe)
    );

    // Vector: {op, req, addr, data}. op 0 write, 1 read-compare,
    // 2 tick data times, 3 compare pin_out, 4 compare pin_oe.
    localparam int NV = 54;
    localparam logic [23:0] VEC [NV] = '{
        24'h0_3_10_00, 24'h0_3_11_03,              // cmp0 = 3
        24'h0_2_03_01, 24'h1_2_03_01,              // R2 ch0 toggle
        24'h3_4_00_00, 24'h4_4_00_01,              // R4 forced output
        24'h2_3_00_03,                             // R3 count to 3
        24'h1_3_04_01, 24'h3_3_00_01,              // R3 flag0, latch0 toggled
        24'h1_1_01_03, 24'h1_1_00_00,              // R1 counter bytes
        24'h0_6_04_00, 24'h1_6_04_01,              // R6 zero write no effect
        24'h0_6_04_01, 24'h1_6_04_00,              // R6 one clears
        24'h0_3_1E_00, 24'h0_3_1F_05,              // cmp7 = 5
        24'h0_2_02_C0, 24'h1_2_02_C0,              // R2 ch7 set-high
        24'h4_4_00_81,
        24'h2_3_00_02,                             // count to 5
        24'h1_3_04_80, 24'h3_3_00_81,              // R3 set action
        24'h0_4_02_00, 24'h4_4_00_01, 24'h3_4_00_01, // R4 disconnect ch7
        24'h0_4_07_80, 24'h0_4_08_80,
        24'h3_4_00_81, 24'h4_4_00_81,              // R4 port drives pin
        24'h0_4_07_00, 24'h3_4_00_01,
        24'h0_5_02_40, 24'h3_5_00_81,              // R5 latch retained
        24'h0_4_08_00, 24'h4_4_00_81,              // R4 forced despite dir 0
        24'h2_3_00_02,                             // count to 7
        24'h0_3_02_80, 24'h0_3_1F_09,              // ch7 clear at 9
        24'h2_3_00_02, 24'h3_3_00_01,              // R3 clear action
        24'h0_6_04_80, 24'h1_6_04_00,              // R6
        24'h0_3_11_0B, 24'h2_3_00_02,              // cmp0 = 11, count to 11
        24'h3_3_00_00, 24'h1_3_04_01,              // R3 toggle back
        24'h0_8_11_0B, 24'h1_8_04_01,              // R8 mode off: kept
        24'h0_8_06_01, 24'h1_8_06_01,              // R8 mode on
        24'h0_8_10_00, 24'h1_8_04_00,              // R8 compare write clears
        24'h1_1_01_0B                              // R1
    };

    // Compare and report one result.
    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    // Bus write: one cycle, starting and ending on a falling edge.
    task automatic bwr(input logic [5:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    // Bus read with compare; side effects happen on the rising edge.
    task automatic brd(input string req, input logic [5:0] a, input logic [7:0] exp);
        bus_addr = a; bus_rd = 1'b1;
        #1;
        chk(req, bus_rdata, exp);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // Hold tick high for n cycles.
    task automatic run_ticks(input int n);
        tick = 1'b1;
        repeat (n) @(negedge clk);
        tick = 1'b0;
    endtask

    // Watchdog: counts as a failed check and still prints the summary.
    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R11: reset state of every register and the pins.
        for (int a = 0; a <= 8; a++) brd("R11", 6'(a), 8'h00);
        brd("R11", 6'h10, 8'h00);
        brd("R11", 6'h1F, 8'h00);
        chk("R11", pin_out, 8'h00);
        chk("R11", pin_oe, 8'h00);

        // Vector table.
        for (int i = 0; i < NV; i++) begin
            automatic logic [3:0] op  = VEC[i][23:20];
            automatic logic [3:0] rq  = VEC[i][19:16];
            automatic logic [5:0] ad  = VEC[i][13:8];
            automatic logic [7:0] dt  = VEC[i][7:0];
            automatic string      tag = $sformatf("R%0d vec %0d", rq, i);
            case (op)
                4'd0: bwr(ad, dt);
                4'd1: brd(tag, ad, dt);
                4'd2: run_ticks(int'(dt));
                4'd3: chk(tag, pin_out, dt);
                default: chk(tag, pin_oe, dt);
            endcase
        end

        // R10: fast-clear compare write on the same edge as a match.
        bwr(6'h11, 8'h0C);
        bus_addr = 6'h10; bus_wdata = 8'h00; bus_wr = 1'b1; tick = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; tick = 1'b0;
        brd("R10", 6'h04, 8'h01);
        chk("R10", pin_out, 8'h01);

        // R7: run from 12 through the wrap to 0.
        run_ticks(65524);
        brd("R7", 6'h05, 8'h80);
        // R9: mode on, counter read clears the overflow flag.
        brd("R9", 6'h01, 8'h00);
        brd("R9", 6'h05, 8'h00);

        // R9: mode off, counter read leaves it set.
        bwr(6'h06, 8'h00);
        run_ticks(65536);
        brd("R9", 6'h00, 8'h00);
        brd("R9", 6'h05, 8'h80);
        // R6: overflow flag write-one clear.
        bwr(6'h05, 8'h00);
        brd("R6", 6'h05, 8'h80);
        bwr(6'h05, 8'h80);
        brd("R6", 6'h05, 8'h00);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule